// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds an 8-bit operand to an 8-bit accumulator one bit per clock. It reuses a single full-adder cell and a carry flip-flop. The result replaces the accumulator. The operand is loaded in parallel from `operand_b` when an addition begins.

A request is a press and release of `start`. Nothing changes while `start` is held. The addition begins only after `start` is released. `zero_acc` selects the addition mode:

- With `zero_acc` high, the accumulator is cleared first, so the result is simply the operand.
- With `zero_acc` low, the operand is added onto whatever the accumulator already holds.

The design has two parts:

- A datapath, clocked on the rising edge, holds the accumulator, the operand register and the carry.
- A controller, clocked on the falling edge, drives a small control bus to the datapath and reports `busy` while an addition runs. Its outputs therefore settle half a cycle before the datapath acts on them.

The interface carries no stream, so all pins are plain control and status levels. There is no back-pressure. A new request is taken only once `busy` is low.

Top module: `serial_accum_adder`

## Requirements
- R1: The accumulator and operand are WIDTH bits (default 8). When an addition ends, `acc_q` holds (previous accumulator or zero) plus `operand_b`, modulo 2^WIDTH; 45 plus 10 from a cleared accumulator gives 55.
- R2: While `start` is held high after a press, `busy` stays low and `acc_q` does not change, however long the press lasts.
- R3: The addition begins at the first falling clock edge that samples `start` low after the press; `busy` is low on every rising edge at which `start` is sampled high before that point.
- R4: With `zero_acc` high at the load step, the accumulator is cleared before adding. With it low, the operand is added onto the existing accumulator value.
- R5: Each addition takes exactly one load cycle plus WIDTH shift cycles, so `busy` is high for WIDTH+1 rising edges and then returns low.
- R6: The carry out of the most significant bit is discarded and never written to `acc_q`; 255 plus 1 leaves 0.
- R7: `sum_bit` shows the full-adder sum for the bit about to be shifted, least significant bit first. Sampled after each of the first WIDTH rising edges with `busy` high, the bits form the result.
- R8: Pressing and releasing `start` while `busy` is high has no effect. No further addition follows, and `acc_q` stays unchanged afterwards.
- R9: Synchronous `reset` returns the controller to idle and clears the accumulator, operand and carry. This holds even in the middle of an addition, and after reset `acc_q` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; datapath on rising edge, controller on falling edge |
| reset | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; press then release to launch one addition |
| zero_acc | input | 1 | Clear accumulator before adding when high at load |
| operand_b | input | WIDTH | Operand, loaded in parallel at the load step |
| acc_q | output | WIDTH | Accumulator contents (the sum) |
| sum_bit | output | 1 | Current serial sum bit from the full-adder cell |
| busy | output | 1 | High from the load step through the last shift |

## Verification
The assertions cover four properties on every cycle:

- The accumulator holds still whenever `busy` is low.
- An addition only begins with `start` released.
- Every busy run lasts exactly WIDTH+1 rising edges.
- Reset leaves the accumulator at zero and the controller idle.

Only the bench's scenarios can show the arithmetic itself. That covers the 45 plus 10 case, accumulation, the carry wrap, and the order of the serial bits. They also show the effect of a stray press during an addition and of a reset in mid-shift, since those need a model of the expected sum.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOAD  = 2'd2,
    ST_SHIFT = 2'd3
  } sacc_state_e;

  typedef struct packed {
    logic load;
    logic clear_acc;
    logic shift;
  } sacc_ctl_t;

endpackage

// File: rtl/sacc_fa.sv
module sacc_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (ci & (a ^ b));
  end
endmodule

// File: rtl/sacc_ctrl.sv
module sacc_ctrl
  import sacc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      reset,
  input  logic      start,
  input  logic      zero_acc,
  output sacc_ctl_t ctl,
  output logic      busy
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  sacc_state_e state;
  logic [CW-1:0] step;

  // Falling-edge sequencing: outputs settle before the datapath's rising edge.
  always_ff @(negedge clk) begin
    if (reset) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_ARMED;
        ST_ARMED: if (!start) state <= ST_LOAD;
        ST_LOAD: begin
          state <= ST_SHIFT;
          step  <= '0;
        end
        ST_SHIFT: begin
          if (step == LAST) state <= ST_IDLE;
          else              step  <= step + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load      = (state == ST_LOAD);
    ctl.clear_acc = (state == ST_LOAD) && zero_acc;
    ctl.shift     = (state == ST_SHIFT);
    busy          = (state == ST_LOAD) || (state == ST_SHIFT);
  end
endmodule

// File: rtl/sacc_datapath.sv
module sacc_datapath
  import sacc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             reset,
  input  sacc_ctl_t        ctl,
  input  logic [WIDTH-1:0] operand_b,
  output logic [WIDTH-1:0] acc_q,
  output logic             sum_bit
);
  logic [WIDTH-1:0] acc_r;
  logic [WIDTH-1:0] opb_r;
  logic             carry_r;
  logic             fa_s;
  logic             fa_co;

  sacc_fa u_fa (
    .a  (acc_r[0]),
    .b  (opb_r[0]),
    .ci (carry_r),
    .s  (fa_s),
    .co (fa_co)
  );

  always_ff @(posedge clk) begin
    if (reset) begin
      acc_r   <= '0;
      opb_r   <= '0;
      carry_r <= 1'b0;
    end else if (ctl.load) begin
      opb_r   <= operand_b;
      carry_r <= 1'b0;
      if (ctl.clear_acc) acc_r <= '0;
    end else if (ctl.shift) begin
      acc_r   <= {fa_s, acc_r[WIDTH-1:1]};
      opb_r   <= {1'b0, opb_r[WIDTH-1:1]};
      carry_r <= fa_co;
    end
  end

  assign acc_q   = acc_r;
  assign sum_bit = fa_s;
endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
  import sacc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             start,
  input  logic             zero_acc,
  input  logic [WIDTH-1:0] operand_b,
  output logic [WIDTH-1:0] acc_q,
  output logic             sum_bit,
  output logic             busy
);
  sacc_ctl_t ctl_bus;

  sacc_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .reset    (reset),
    .start    (start),
    .zero_acc (zero_acc),
    .ctl      (ctl_bus),
    .busy     (busy)
  );

  sacc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .reset     (reset),
    .ctl       (ctl_bus),
    .operand_b (operand_b),
    .acc_q     (acc_q),
    .sum_bit   (sum_bit)
  );
endmodule

// File: rtl/sacc_chk.sv
module sacc_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             reset,
  input logic             start,
  input logic             busy,
  input logic [WIDTH-1:0] acc_q
);
  localparam int RW = $clog2(WIDTH + 2) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (reset)     run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (reset)
    !busy |=> $stable(acc_q));

  // R3
  release_launch_chk: assert property (@(posedge clk) disable iff (reset)
    $rose(busy) |-> !start);

  // R5
  run_length_chk: assert property (@(posedge clk) disable iff (reset)
    $fell(busy) |-> (run_len == RW'(WIDTH + 1)));

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (reset)
    busy |-> (run_len <= RW'(WIDTH)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    reset |=> (acc_q == '0) && !busy);
endmodule

bind serial_accum_adder sacc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .reset (reset),
  .start (start),
  .busy  (busy),
  .acc_q (acc_q)
);

// File: tb/serial_accum_adder_test.sv
`timescale 1ns/1ps
module serial_accum_adder_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         reset = 1'b1;
  logic         start = 1'b0;
  logic         zero_acc = 1'b0;
  logic [W-1:0] operand_b = '0;
  logic [W-1:0] acc_q;
  logic         sum_bit;
  logic         busy;

  int n_checks = 0;
  int n_fails  = 0;
  logic [W-1:0] model = '0;

  serial_accum_adder #(.WIDTH(W)) uut (
    .clk       (clk),
    .reset     (reset),
    .start     (start),
    .zero_acc  (zero_acc),
    .operand_b (operand_b),
    .acc_q     (acc_q),
    .sum_bit   (sum_bit),
    .busy      (busy)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One press/release addition; optional stray press during busy.
  task automatic run_add(input logic [W-1:0] b, input logic clr, input int hold,
                         input logic stray);
    logic [W-1:0] bits = '0;
    int bcount = 0;
    logic [W-1:0] expv;
    @(posedge clk); #1;
    operand_b = b; zero_acc = clr; start = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      chk("R2 busy low while held", int'(busy), 0);
      chk("R3 no launch before release", int'(acc_q), int'(model));
    end
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (busy) begin
        if (bcount < W) bits[bcount] = sum_bit;
        bcount++;
        if (stray && bcount == 3) start = 1'b1;
        if (stray && bcount == 5) start = 1'b0;
      end else if (bcount != 0) begin
        break;
      end
    end
    expv  = (clr ? '0 : model) + b;
    model = expv;
    zero_acc = 1'b0;
    chk("R1/R4 result", int'(acc_q), int'(expv));
    chk("R5 busy length", bcount, W + 1);
    chk("R7 serial bits", int'(bits), int'(expv));
  endtask

  task automatic t_reset_state();
    chk("R9 reset acc", int'(acc_q), 0);
    chk("R9 reset busy", int'(busy), 0);
  endtask

  task automatic t_basic();
    run_add(8'd10, 1'b0, 1, 1'b0);
    run_add(8'd45, 1'b1, 2, 1'b0);
    run_add(8'd10, 1'b0, 1, 1'b0);
    chk("R1 45+10", int'(acc_q), 55);
  endtask

  task automatic t_long_hold();
    run_add(8'd3, 1'b0, 12, 1'b0);
    chk("R2 long press result", int'(acc_q), 58);
  endtask

  task automatic t_clear_mode();
    run_add(8'hA5, 1'b1, 1, 1'b0);
    chk("R4 cleared then added", int'(acc_q), 165);
    run_add(8'h5A, 1'b0, 1, 1'b0);
    chk("R4 accumulated", int'(acc_q), 255);
  endtask

  task automatic t_wrap();
    run_add(8'd1, 1'b0, 1, 1'b0);
    chk("R6 carry dropped", int'(acc_q), 0);
    run_add(8'hFF, 1'b1, 1, 1'b0);
    run_add(8'hFF, 1'b0, 1, 1'b0);
    chk("R6 255+255", int'(acc_q), 254);
  endtask

  task automatic t_stray_press();
    run_add(8'd7, 1'b1, 1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk("R8 no second run busy", int'(busy), 0);
    end
    chk("R8 acc unchanged", int'(acc_q), 7);
  endtask

  task automatic t_mid_reset();
    int seen = 0;
    @(posedge clk); #1;
    operand_b = 8'd99; zero_acc = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 20 && seen < 3; i++) begin
      @(posedge clk); #1;
      if (busy) seen++;
    end
    reset = 1'b1;
    @(posedge clk); #1;
    reset = 1'b0;
    chk("R9 mid-run acc cleared", int'(acc_q), 0);
    chk("R9 mid-run idle", int'(busy), 0);
    model = '0;
    run_add(8'd20, 1'b0, 1, 1'b0);
    chk("R9 acc was zero after reset", int'(acc_q), 20);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset_state();
    reset = 1'b0;
    t_basic();
    t_long_hold();
    t_clear_mode();
    t_wrap();
    t_stray_press();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule